// File: doc/BRIEF.md
# SMBus Host Block-Transfer Controller

This block is the register front end of an SMBus host. Software reaches it through a byte-wide register port with a 4-bit offset. It stages a transaction in the command, target-address and data-0 registers. It fills a block buffer of up to 32 bytes through one auto-incrementing data port. It then sets the start bit in the control register. A sequencer turns the request into a series of byte-level operations for an external bus engine: start condition, stop condition, send byte, receive byte. The engine does the wire timing and reports back whether the target acknowledged.

Block writes send the count from data-0, followed by the payload taken from the buffer. Block reads use a repeated start. The count byte returned by the target goes into data-0, and the data bytes go into the buffer, where software drains them through the same port. Completion, device error and kill-abort are reported in separate sticky status bits, which software clears by writing ones to them. A live busy bit covers the whole transaction.

Top module: `smbh_top`

## Requirements
- R1: After reset, every register reads 0x00: status (offset 0x0), control (0x2), command (0x3), target address (0x4), data-0 (0x5), data-1 (0x6) and auxiliary (0xD).
- R2: Reading control resets the buffer index to 0. Each read or write of the block port (offset 0x7) accesses the buffer byte at the index and then advances the index by one.
- R3: Command, target address, data-0 and data-1 read back as written. Auxiliary keeps only bits 1:0. Control reads back interrupt-enable (bit0), protocol (bits 4:2), last-byte (bit5) and PEC-enable (bit7); start (bit6) and kill (bit1) always read 0.
- R4: A control write with bit6 set starts a transaction only when the same write carries protocol value 5 in bits 4:2 and no transaction is in progress. Otherwise no bus operation is issued.
- R5: When target-address bit0 is 0, a transaction is a block write. The bus sees start, {addr[7:1],0}, command, the data-0 count, the count payload bytes from buffer bytes 0 up, and then stop.
- R6: Status bit0 (busy) is 1 from the accepted start until the final stop completes. A transaction that finishes without error sets bit1. Status bits 4:1 are cleared by writing 1 to them, and a hardware set in the same cycle wins.
- R7: When target-address bit0 is 1, a transaction is a block read. The bus sees start, {addr,0}, command, a repeated start, {addr,1}, a receive of the count, and then count receives. Only the last receive is answered with NACK, and a stop follows.
- R8: On a block read, the received count byte is written into data-0, and data byte k is stored in buffer byte k.
- R9: A NACK to any sent byte ends the transaction with a stop, sets status bit2 and clears busy.
- R10: A count of 0 or above 32 sets status bit2. On a read, the received count is still stored and a stop follows at once. On a write, no bus operation is issued at all.
- R11: Writing control with bit1 set during a transaction lets the current operation finish, then issues a stop and sets status bit4 instead of bit1.
- R12: At most one bus-engine operation is outstanding. The operation-valid strobe lasts one cycle, and the next one waits for the engine's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on control and block port) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| eng_op_valid | output | 1 | One-cycle request for a bus-engine operation |
| eng_op | output | 2 | Operation: 0 start, 1 stop, 2 send, 3 receive |
| eng_tx_byte | output | 8 | Byte for a send operation |
| eng_rx_nack | output | 1 | Answer this receive with NACK |
| eng_done | input | 1 | Engine finished the outstanding operation |
| eng_acked | input | 1 | Target acknowledged the sent byte (valid with eng_done) |
| eng_rx_byte | input | 8 | Received byte (valid with eng_done) |

## Verification
The bench runs a three-byte write and a four-byte read against a scripted engine model. It compares the full logged operation list, including send bytes and NACK flags, so a missing repeated start or a wrong direction bit shows up in the log. Error patterns each end at a different point in the sequence: a NACK on the first address byte, read counts of 0 and 33, a write count of 0, and a kill issued mid-transfer. They are told apart by the operation count and by which status bit is set. Buffer index behaviour is checked by draining, rewinding through a control read and draining again, and a start with a non-block protocol confirms that no operation leaves the block.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam logic [3:0] OFS_STAT = 4'h0;
    localparam logic [3:0] OFS_CTL  = 4'h2;
    localparam logic [3:0] OFS_CMD  = 4'h3;
    localparam logic [3:0] OFS_XADR = 4'h4;
    localparam logic [3:0] OFS_D0   = 4'h5;
    localparam logic [3:0] OFS_D1   = 4'h6;
    localparam logic [3:0] OFS_BLK  = 4'h7;
    localparam logic [3:0] OFS_AUX  = 4'hD;

    localparam logic [2:0] PROTO_BLOCK = 3'd5;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_STOP  = 2'd1,
        ENG_SEND  = 2'd2,
        ENG_RECV  = 2'd3
    } eng_op_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_DEVERR = 2'd1,
        RES_FAILED = 2'd2
    } res_e;

    typedef enum logic [3:0] {
        PH_START, PH_ADDR, PH_CMD, PH_WCNT, PH_WDATA,
        PH_RSTART, PH_RADDR, PH_RCNT, PH_RDATA, PH_STOP
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_ISSUE, SQ_WAIT
    } seq_st_e;

    // status bit that a finished transaction sets
    function automatic logic [7:0] res_mask(res_e r);
        case (r)
            RES_OK:     return 8'h02;
            RES_DEVERR: return 8'h04;
            RES_FAILED: return 8'h10;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic count_bad(logic [7:0] c, int unsigned lim);
        return (c == 8'd0) || (32'(c) > lim);
    endfunction

endpackage

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [7:0]    sw_wdata,
    output logic [7:0]    sw_rdata,
    input  logic          hw_we,
    input  logic [AW-1:0] hw_addr,
    input  logic [7:0]    hw_wdata,
    input  logic [AW-1:0] hw_raddr,
    output logic [7:0]    hw_rdata
);
    logic [7:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 8'h00;
            else if (hw_we && hw_addr == AW'(g))
                q <= hw_wdata;
            else if (sw_we && sw_addr == AW'(g))
                q <= sw_wdata;
        end
        assign ent[g] = q;
    end

    assign sw_rdata = ent[sw_addr];
    assign hw_rdata = ent[hw_raddr];
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
#(
    parameter int unsigned MAX_BLK = 32,
    localparam int unsigned IW = $clog2(MAX_BLK)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          kill,
    input  logic          rd_dir,
    input  logic [6:0]    addr7,
    input  logic [7:0]    cmd,
    input  logic [7:0]    wcount,
    output logic          eng_op_valid,
    output eng_op_e       eng_op,
    output logic [7:0]    eng_tx_byte,
    output logic          eng_rx_nack,
    input  logic          eng_done,
    input  logic          eng_acked,
    input  logic [7:0]    eng_rx_byte,
    output logic [IW-1:0] buf_idx,
    input  logic [7:0]    buf_rdata,
    output logic          buf_we,
    output logic          cnt_we,
    output logic          busy,
    output logic          done,
    output res_e          res
);
    seq_st_e       st_q;
    phase_e        ph_q;
    logic          dir_q, kill_q;
    logic [6:0]    addr_q;
    logic [7:0]    cmd_q, cnt_q;
    logic [IW-1:0] idx_q;
    res_e          res_q;

    logic last, step, early_bad;
    assign last      = ({{(8-IW){1'b0}}, idx_q} + 8'd1) == cnt_q;
    assign step      = (st_q == SQ_WAIT) && eng_done;
    assign early_bad = (st_q == SQ_IDLE) && start && !rd_dir && count_bad(wcount, MAX_BLK);

    always_comb begin
        case (ph_q)
            PH_START, PH_RSTART: eng_op = ENG_START;
            PH_STOP:             eng_op = ENG_STOP;
            PH_RCNT, PH_RDATA:   eng_op = ENG_RECV;
            default:             eng_op = ENG_SEND;
        endcase
        case (ph_q)
            PH_ADDR:  eng_tx_byte = {addr_q, 1'b0};
            PH_RADDR: eng_tx_byte = {addr_q, 1'b1};
            PH_CMD:   eng_tx_byte = cmd_q;
            PH_WCNT:  eng_tx_byte = cnt_q;
            PH_WDATA: eng_tx_byte = buf_rdata;
            default:  eng_tx_byte = 8'h00;
        endcase
    end

    assign eng_op_valid = (st_q == SQ_ISSUE);
    assign eng_rx_nack  = eng_op_valid && ph_q == PH_RDATA && last;
    assign buf_idx      = idx_q;
    assign buf_we       = step && ph_q == PH_RDATA;
    assign cnt_we       = step && ph_q == PH_RCNT;
    assign busy         = (st_q != SQ_IDLE);
    assign done         = early_bad || (step && ph_q == PH_STOP);
    assign res          = early_bad ? RES_DEVERR : res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            ph_q   <= PH_START;
            dir_q  <= 1'b0;
            kill_q <= 1'b0;
            addr_q <= '0;
            cmd_q  <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            res_q  <= RES_OK;
        end else begin
            if (busy && kill) kill_q <= 1'b1;
            case (st_q)
                SQ_IDLE: if (start && !early_bad) begin
                    st_q   <= SQ_ISSUE;
                    ph_q   <= PH_START;
                    dir_q  <= rd_dir;
                    addr_q <= addr7;
                    cmd_q  <= cmd;
                    cnt_q  <= wcount;
                    idx_q  <= '0;
                    kill_q <= 1'b0;
                    res_q  <= RES_OK;
                end
                SQ_ISSUE: st_q <= SQ_WAIT;
                SQ_WAIT: if (eng_done) begin
                    if (ph_q == PH_STOP) begin
                        st_q <= SQ_IDLE;
                    end else begin
                        st_q <= SQ_ISSUE;
                        if (eng_op == ENG_SEND && !eng_acked) begin
                            res_q <= RES_DEVERR;
                            ph_q  <= PH_STOP;
                        end else if (kill_q) begin
                            res_q <= RES_FAILED;
                            ph_q  <= PH_STOP;
                        end else begin
                            case (ph_q)
                                PH_START:  ph_q <= PH_ADDR;
                                PH_ADDR:   ph_q <= PH_CMD;
                                PH_CMD:    ph_q <= dir_q ? PH_RSTART : PH_WCNT;
                                PH_WCNT:   ph_q <= PH_WDATA;
                                PH_WDATA: begin
                                    if (last) ph_q <= PH_STOP;
                                    else      idx_q <= idx_q + 1'b1;
                                end
                                PH_RSTART: ph_q <= PH_RADDR;
                                PH_RADDR:  ph_q <= PH_RCNT;
                                PH_RCNT: begin
                                    if (count_bad(eng_rx_byte, MAX_BLK)) begin
                                        res_q <= RES_DEVERR;
                                        ph_q  <= PH_STOP;
                                    end else begin
                                        cnt_q <= eng_rx_byte;
                                        idx_q <= '0;
                                        ph_q  <= PH_RDATA;
                                    end
                                end
                                PH_RDATA: begin
                                    if (last) ph_q <= PH_STOP;
                                    else      idx_q <= idx_q + 1'b1;
                                end
                                default:   ph_q <= PH_STOP;
                            endcase
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smbh_top.sv
module smbh_top
    import smbh_pkg::*;
#(
    parameter int unsigned MAX_BLK = 32,
    localparam int unsigned IW = $clog2(MAX_BLK)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       eng_op_valid,
    output logic [1:0] eng_op,
    output logic [7:0] eng_tx_byte,
    output logic       eng_rx_nack,
    input  logic       eng_done,
    input  logic       eng_acked,
    input  logic [7:0] eng_rx_byte
);
    logic [7:0]    stat_q;
    logic [2:0]    proto_q;
    logic          intren_q, last_q, pec_q;
    logic [7:0]    cmd_q, xadr_q, d0_q, d1_q;
    logic [1:0]    aux_q;
    logic [IW-1:0] sw_idx_q;

    logic          seq_busy, seq_done, seq_buf_we, seq_cnt_we;
    res_e          seq_res;
    eng_op_e       seq_op;
    logic [IW-1:0] seq_idx;
    logic [7:0]    sw_rdata, hw_rdata;

    logic wr_ctl, start_req, kill_req, blk_acc, blk_wr;
    assign wr_ctl    = reg_wr && reg_addr == OFS_CTL;
    assign start_req = wr_ctl && reg_wdata[6] && reg_wdata[4:2] == PROTO_BLOCK && !seq_busy;
    assign kill_req  = wr_ctl && reg_wdata[1];
    assign blk_wr    = reg_wr && reg_addr == OFS_BLK;
    assign blk_acc   = (reg_wr || reg_rd) && reg_addr == OFS_BLK;

    smbh_blkbuf #(.DEPTH(MAX_BLK)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (blk_wr),
        .sw_addr  (sw_idx_q),
        .sw_wdata (reg_wdata),
        .sw_rdata (sw_rdata),
        .hw_we    (seq_buf_we),
        .hw_addr  (seq_idx),
        .hw_wdata (eng_rx_byte),
        .hw_raddr (seq_idx),
        .hw_rdata (hw_rdata)
    );

    smbh_seq #(.MAX_BLK(MAX_BLK)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start_req),
        .kill         (kill_req),
        .rd_dir       (xadr_q[0]),
        .addr7        (xadr_q[7:1]),
        .cmd          (cmd_q),
        .wcount       (d0_q),
        .eng_op_valid (eng_op_valid),
        .eng_op       (seq_op),
        .eng_tx_byte  (eng_tx_byte),
        .eng_rx_nack  (eng_rx_nack),
        .eng_done     (eng_done),
        .eng_acked    (eng_acked),
        .eng_rx_byte  (eng_rx_byte),
        .buf_idx      (seq_idx),
        .buf_rdata    (hw_rdata),
        .buf_we       (seq_buf_we),
        .cnt_we       (seq_cnt_we),
        .busy         (seq_busy),
        .done         (seq_done),
        .res          (seq_res)
    );

    assign eng_op = seq_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= '0;
            proto_q  <= '0;
            intren_q <= 1'b0;
            last_q   <= 1'b0;
            pec_q    <= 1'b0;
            cmd_q    <= '0;
            xadr_q   <= '0;
            d0_q     <= '0;
            d1_q     <= '0;
            aux_q    <= '0;
            sw_idx_q <= '0;
        end else begin
            stat_q <= (stat_q & ~((reg_wr && reg_addr == OFS_STAT) ? (reg_wdata & 8'h1E) : 8'h00))
                      | (seq_done ? res_mask(seq_res) : 8'h00);
            if (wr_ctl) begin
                intren_q <= reg_wdata[0];
                proto_q  <= reg_wdata[4:2];
                last_q   <= reg_wdata[5];
                pec_q    <= reg_wdata[7];
            end
            if (reg_wr && reg_addr == OFS_CMD)  cmd_q  <= reg_wdata;
            if (reg_wr && reg_addr == OFS_XADR) xadr_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_D1)   d1_q   <= reg_wdata;
            if (reg_wr && reg_addr == OFS_AUX)  aux_q  <= reg_wdata[1:0];
            if (seq_cnt_we)
                d0_q <= eng_rx_byte;
            else if (reg_wr && reg_addr == OFS_D0)
                d0_q <= reg_wdata;
            if (reg_rd && reg_addr == OFS_CTL)
                sw_idx_q <= '0;
            else if (blk_acc)
                sw_idx_q <= sw_idx_q + 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_STAT: reg_rdata = stat_q | {7'b0, seq_busy};
            OFS_CTL:  reg_rdata = {pec_q, 1'b0, last_q, proto_q, 1'b0, intren_q};
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_XADR: reg_rdata = xadr_q;
            OFS_D0:   reg_rdata = d0_q;
            OFS_D1:   reg_rdata = d1_q;
            OFS_BLK:  reg_rdata = sw_rdata;
            OFS_AUX:  reg_rdata = {6'b0, aux_q};
            default:  reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/smbh_checker.sv
module smbh_checker (
    input logic       clk,
    input logic       rst,
    input logic       eng_op_valid,
    input logic [1:0] eng_op,
    input logic       eng_rx_nack,
    input logic       eng_done,
    input logic       busy,
    input logic       done,
    input logic [7:0] stat_q
);
    // R12: an issued operation is never followed directly by another
    p_single_op_r12: assert property (@(posedge clk) disable iff (rst)
        eng_op_valid |=> !eng_op_valid);

    // R4: nothing reaches the engine outside a transaction
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_op_valid);

    // R6: busy only drops as the engine reports the final operation
    p_busy_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(eng_done));

    // R6: every finish leaves a result bit in status
    p_done_flag_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (stat_q[1] || stat_q[2] || stat_q[4]));

    // R7: NACK answer is only requested on a receive
    p_nack_recv_r7: assert property (@(posedge clk) disable iff (rst)
        eng_rx_nack |-> (eng_op_valid && eng_op == 2'd3));
endmodule

bind smbh_top smbh_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .eng_op_valid (eng_op_valid),
    .eng_op       (eng_op),
    .eng_rx_nack  (eng_rx_nack),
    .eng_done     (eng_done),
    .busy         (seq_busy),
    .done         (seq_done),
    .stat_q       (stat_q)
);

// File: tb/tb_smbh_top.sv
`timescale 1ns/1ps
module tb_smbh_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_op_valid;
    logic [1:0] eng_op;
    logic [7:0] eng_tx_byte;
    logic       eng_rx_nack;
    logic       eng_done = 1'b0;
    logic       eng_acked = 1'b0;
    logic [7:0] eng_rx_byte = '0;

    int checks = 0;
    int errors = 0;

    // engine model state
    int         log_n = 0;
    logic [1:0] log_op [64];
    logic [7:0] log_byte [64];
    logic       log_nack [64];
    int         send_n = 0;
    int         recv_n = 0;
    int         nack_at = -1;
    logic [7:0] rx_script [40];

    always #2 clk = ~clk;

    smbh_top dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_op_valid(eng_op_valid),
        .eng_op(eng_op), .eng_tx_byte(eng_tx_byte), .eng_rx_nack(eng_rx_nack),
        .eng_done(eng_done), .eng_acked(eng_acked), .eng_rx_byte(eng_rx_byte)
    );

    // bus engine model: answers each operation one cycle later
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (eng_op_valid) begin
                if (log_n < 64) begin
                    log_op[log_n]   = eng_op;
                    log_byte[log_n] = eng_tx_byte;
                    log_nack[log_n] = eng_rx_nack;
                    log_n++;
                end
                eng_acked = 1'b1;
                if (eng_op == 2'd2) begin
                    eng_acked = (send_n != nack_at);
                    send_n++;
                end
                if (eng_op == 2'd3) begin
                    eng_rx_byte = rx_script[recv_n % 40];
                    recv_n++;
                end
                @(negedge clk);
                eng_done = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_log();
        log_n = 0; send_n = 0; recv_n = 0; nack_at = -1;
        wr(4'h0, 8'hFF);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 500; i++) begin
            rd(4'h0, s);
            if (!s[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(4'h0, d); chk("R1 status", d, 8'h00);
        rd(4'h2, d); chk("R1 control", d, 8'h00);
        rd(4'h5, d); chk("R1 data0", d, 8'h00);
        rd(4'hD, d); chk("R1 aux", d, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(4'h3, 8'h3C); rd(4'h3, d); chk("R3 command", d, 8'h3C);
        wr(4'h6, 8'h22); rd(4'h6, d); chk("R3 data1", d, 8'h22);
        wr(4'hD, 8'hFF); rd(4'hD, d); chk("R3 aux", d, 8'h03);
        wr(4'h2, 8'hEB); rd(4'h2, d); chk("R3 control", d, 8'hA9);
        chk("R4 no op on non-block start", log_n, 0);
        wr(4'h2, 8'h00);
    endtask

    task automatic t_proto_gate();
        logic [7:0] d;
        clear_log();
        wr(4'h4, 8'hA0); wr(4'h5, 8'h01);
        wr(4'h2, 8'h44);
        repeat (10) @(negedge clk);
        chk("R4 ops with proto 1", log_n, 0);
        rd(4'h0, d); chk("R4 status", d, 8'h00);
    endtask

    task automatic t_block_write();
        logic [7:0] d;
        clear_log();
        rd(4'h2, d);
        wr(4'h7, 8'h11); wr(4'h7, 8'h22); wr(4'h7, 8'h33);
        wr(4'h4, 8'hA0); wr(4'h3, 8'hA5); wr(4'h5, 8'h03);
        wr(4'h2, 8'h54);
        rd(4'h0, d); chk("R6 busy during write", d[0], 1);
        wait_idle();
        chk("R5 op count", log_n, 8);
        chk("R5 op0 start", log_op[0], 0);
        chk("R5 addr byte", log_byte[1], 8'hA0);
        chk("R5 command byte", log_byte[2], 8'hA5);
        chk("R5 count byte", log_byte[3], 8'h03);
        chk("R5 payload0", log_byte[4], 8'h11);
        chk("R5 payload2", log_byte[6], 8'h33);
        chk("R5 last stop", log_op[7], 1);
        rd(4'h0, d); chk("R6 done bit", d, 8'h02);
        wr(4'h0, 8'h02); rd(4'h0, d); chk("R6 W1C clear", d, 8'h00);
    endtask

    task automatic t_block_read();
        logic [7:0] d;
        clear_log();
        rx_script[0] = 8'd4;
        rx_script[1] = 8'hD0; rx_script[2] = 8'hD1;
        rx_script[3] = 8'hD2; rx_script[4] = 8'hD3;
        wr(4'h4, 8'h59); wr(4'h3, 8'h07);
        wr(4'h2, 8'h54);
        wait_idle();
        chk("R7 op count", log_n, 11);
        chk("R7 first addr write dir", log_byte[1], 8'h58);
        chk("R7 repeated start", log_op[3], 0);
        chk("R7 read addr", log_byte[4], 8'h59);
        chk("R7 count acked", log_nack[5], 0);
        chk("R7 mid data acked", log_nack[8], 0);
        chk("R7 last data nacked", log_nack[9], 1);
        chk("R7 stop", log_op[10], 1);
        rd(4'h5, d); chk("R8 data0 count", d, 4);
        rd(4'h2, d);
        for (int k = 0; k < 4; k++) begin
            rd(4'h7, d); chk("R8 buffer byte", d, 8'hD0 + k);
        end
        rd(4'h2, d);
        rd(4'h7, d); chk("R2 index rewinds", d, 8'hD0);
        rd(4'h7, d); chk("R2 index advances", d, 8'hD1);
        rd(4'h0, d); chk("R6 done after read", d, 8'h02);
    endtask

    task automatic t_nack();
        logic [7:0] d;
        clear_log();
        nack_at = 0;
        wr(4'h4, 8'hA0); wr(4'h5, 8'h02);
        wr(4'h2, 8'h54);
        wait_idle();
        chk("R9 op count", log_n, 3);
        chk("R9 stop after nack", log_op[2], 1);
        rd(4'h0, d); chk("R9 device error", d, 8'h04);
    endtask

    task automatic t_bad_counts();
        logic [7:0] d;
        clear_log();
        rx_script[0] = 8'd0;
        wr(4'h4, 8'h59); wr(4'h2, 8'h54);
        wait_idle();
        chk("R10 zero count ops", log_n, 7);
        rd(4'h0, d); chk("R10 zero count status", d, 8'h04);
        rd(4'h5, d); chk("R10 zero count stored", d, 0);
        clear_log();
        rx_script[0] = 8'd33;
        wr(4'h2, 8'h54);
        wait_idle();
        chk("R10 count 33 stop", log_op[6], 1);
        rd(4'h0, d); chk("R10 count 33 status", d, 8'h04);
        rd(4'h5, d); chk("R10 count 33 stored", d, 33);
        clear_log();
        wr(4'h4, 8'hA0); wr(4'h5, 8'h00); wr(4'h2, 8'h54);
        repeat (6) @(negedge clk);
        chk("R10 write count 0 no ops", log_n, 0);
        rd(4'h0, d); chk("R10 write count 0 status", d, 8'h04);
    endtask

    task automatic t_kill();
        logic [7:0] d;
        clear_log();
        wr(4'h4, 8'hA0); wr(4'h5, 8'h05);
        wr(4'h2, 8'h54);
        wr(4'h2, 8'h16);
        wait_idle();
        chk("R11 cut short", (log_n < 9) ? 1 : 0, 1);
        chk("R11 ends in stop", log_op[log_n - 1], 1);
        rd(4'h0, d); chk("R11 failed bit", d, 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_proto_gate();
        t_block_write();
        t_block_read();
        t_nack();
        t_bad_counts();
        t_kill();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule